// File: doc/BRIEF.md
# Wear-Leveling Page Translator

This block sits between a host that reads and writes fixed-size logical pages and a flash-style array that can program one erased page at a time and can only return pages to the erased state a whole block at a time. It keeps a table from each logical page to the physical page that holds its newest copy, a three-way state for every physical page (erased, live, stale) and an erase counter for every block. A write never overwrites in place. The data lands on an erased page, the table entry moves to that page, and the page it left becomes stale.

When a write leaves fewer than one block's worth of erased pages, the block is reclaimed before the host gets control back. The block with the most stale pages is chosen, its live pages are copied elsewhere, and it is erased. After each reclaim the erase counters are compared. When the gap between the most-worn and least-worn block is above a programmable limit, the live data of the least-worn block moves into the most-worn fully erased block. The least-worn block is then erased, so it can take new writes.

Host requests use valid/ready. `req_ready` is high only when the block is idle and no response is waiting. The host must hold a request stable while `req_valid` is high and `req_ready` is low. A read answer stays on `rsp_rdata` with `rsp_valid` high until the cycle in which `rsp_ready` is high, and no new request is taken meanwhile. The array port is plain: one strobe per cycle, with read data returned combinationally in the same cycle. Physical page number is `block*PPB + offset`. The number of logical pages must not exceed `(NBLK-2)*PPB`, so that a reclaim always has room for its copies.

Top module: `wl_ftl`

## Requirements
- R1: A read of a logical page that has been written returns the data of the last accepted write to it, including after any number of reclaims and migrations.
- R2: In the cycle after a write is accepted, exactly one program strobe is issued, carrying the write data, to a physical page that is erased at that moment. Every program of any kind targets an erased page.
- R3: A read of a logical page never written since reset returns 8'hFF (all ones at DW bits) and issues no array read. Any read produces either an array read or a response in the cycle after acceptance.
- R4: A write after which fewer than PPB erased pages remain triggers exactly one reclaim. The victim is the block with the most stale pages, ties going to the lower erase count and then to the lower block index. All its live pages are copied, data unchanged, to erased pages of other blocks before it is erased.
- R5: After a reclaim erase, a migration runs if and only if these three conditions hold: (max − min) of the erase counts exceeds `lvl_gap_limit`; a fully erased block exists; and the least-worn block (lowest count, lowest index on ties) is not fully erased. Its live pages go to the fully erased block with the highest count (lowest index on ties), and then the least-worn block is erased.
- R6: While a read, write, reclaim or migration is in progress, `req_ready` is low, and at most one of `fl_rd`, `fl_prog`, `fl_erase` is high in any cycle.
- R7: Once `rsp_valid` is high, it stays high with `rsp_rdata` unchanged until a cycle with `rsp_ready` high.
- R8: After reset, `req_ready` is high, `rsp_valid` is low and no array strobe is active.
- R9: An erase carries the block in `fl_addr` as `block*PPB`, with the offset bits zero, and raises that block's erase count by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl_gap_limit | input | ECW | Erase-count gap above which migration runs |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request accepted when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lpa | input | log2(NLP) | Logical page |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Host takes read data |
| rsp_rdata | output | DW | Read data |
| fl_rd | output | 1 | Array page read strobe |
| fl_prog | output | 1 | Array page program strobe |
| fl_erase | output | 1 | Array block erase strobe |
| fl_addr | output | log2(NBLK*PPB) | Physical page, or block base for erase |
| fl_wdata | output | DW | Program data |
| fl_rdata | input | DW | Array read data, same cycle as fl_rd |

## Verification
A first read of a page that was never written tells the bypass path apart from a real array access. A fixed cold set followed by a long stream of rewrites to a small hot set must end in a migration, and a later readback of the cold pages shows whether moved data kept its table entries. A long random mix of reads and writes with random response back-pressure is checked on every array strobe against a page-state model in the bench. That model gives the expected victim, migration source and destination, and copy data, and so separates a wrong choice of block from lost or stale data.

// File: rtl/wl_pkg.sv
package wl_pkg;
  typedef enum logic [1:0] {
    PG_ERASED = 2'd0,
    PG_LIVE   = 2'd1,
    PG_STALE  = 2'd2
  } pg_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_WR,
    S_PICK,
    S_CPRD,
    S_CPWR,
    S_ERASE,
    S_CHKM
  } fsm_t;
endpackage

// File: rtl/wl_select.sv
module wl_select #(
  parameter int NBLK = 4,
  parameter int PPB  = 4,
  parameter int ECW  = 12,
  localparam int BAW = $clog2(NBLK),
  localparam int NPG = NBLK * PPB,
  localparam int CW  = $clog2(PPB + 1)
) (
  input  wl_pkg::pg_t    pst [NPG],
  input  logic [ECW-1:0] ec  [NBLK],
  output logic [BAW-1:0] vic_blk,
  output logic [BAW-1:0] cold_blk,
  output logic [BAW-1:0] dst_blk,
  output logic           dst_ok,
  output logic           cold_used,
  output logic [ECW-1:0] spread
);
  logic [CW-1:0]  stale_n [NBLK];
  logic [NBLK-1:0] used;

  always_comb begin
    for (int b = 0; b < NBLK; b++) begin
      stale_n[b] = '0;
      used[b]    = 1'b0;
      for (int p = 0; p < PPB; p++) begin
        if (pst[b*PPB+p] == wl_pkg::PG_STALE) stale_n[b] = stale_n[b] + CW'(1);
        if (pst[b*PPB+p] != wl_pkg::PG_ERASED) used[b] = 1'b1;
      end
    end
  end

  always_comb begin : c_pick
    logic [CW-1:0]  bs;
    logic [ECW-1:0] be, mn, mx, de;
    vic_blk  = '0;
    bs       = stale_n[0];
    be       = ec[0];
    cold_blk = '0;
    mn       = ec[0];
    mx       = ec[0];
    dst_ok   = 1'b0;
    dst_blk  = '0;
    de       = '0;
    for (int b = 1; b < NBLK; b++) begin
      if (stale_n[b] > bs || (stale_n[b] == bs && ec[b] < be)) begin
        vic_blk = BAW'(b);
        bs      = stale_n[b];
        be      = ec[b];
      end
      if (ec[b] < mn) begin
        mn       = ec[b];
        cold_blk = BAW'(b);
      end
      if (ec[b] > mx) mx = ec[b];
    end
    for (int b = 0; b < NBLK; b++) begin
      if (!used[b] && (!dst_ok || ec[b] > de)) begin
        dst_ok  = 1'b1;
        dst_blk = BAW'(b);
        de      = ec[b];
      end
    end
    cold_used = used[cold_blk];
    spread    = mx - mn;
  end
endmodule

// File: rtl/wl_alloc.sv
module wl_alloc #(
  parameter int NBLK = 4,
  parameter int PPB  = 4,
  localparam int NPG = NBLK * PPB,
  localparam int PAW = $clog2(NPG)
) (
  input  wl_pkg::pg_t     pst [NPG],
  input  logic [NBLK-1:0] blk_mask,
  output logic            ok,
  output logic [PAW-1:0]  ppa,
  output logic [PAW:0]    free_cnt
);
  always_comb begin
    ok       = 1'b0;
    ppa      = '0;
    free_cnt = '0;
    for (int p = NPG - 1; p >= 0; p--) begin
      if (pst[p] == wl_pkg::PG_ERASED) begin
        free_cnt = free_cnt + (PAW+1)'(1);
        if (blk_mask[p/PPB]) begin
          ok  = 1'b1;
          ppa = PAW'(p);
        end
      end
    end
  end
endmodule

// File: rtl/wl_ftl.sv
module wl_ftl #(
  parameter int NBLK = 4,
  parameter int PPB  = 4,
  parameter int NLP  = 8,
  parameter int DW   = 8,
  parameter int ECW  = 12,
  localparam int NPG = NBLK * PPB,
  localparam int PAW = $clog2(NPG),
  localparam int BAW = $clog2(NBLK),
  localparam int LAW = $clog2(NLP),
  localparam int OFW = $clog2(PPB)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [ECW-1:0] lvl_gap_limit,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [LAW-1:0] req_lpa,
  input  logic [DW-1:0]  req_wdata,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic [DW-1:0]  rsp_rdata,
  output logic           fl_rd,
  output logic           fl_prog,
  output logic           fl_erase,
  output logic [PAW-1:0] fl_addr,
  output logic [DW-1:0]  fl_wdata,
  input  logic [DW-1:0]  fl_rdata
);
  import wl_pkg::*;

  fsm_t           st;
  pg_t            pst     [NPG];
  logic [LAW-1:0] own     [NPG];
  logic [PAW-1:0] map_ppa [NLP];
  logic [NLP-1:0] map_ok;
  logic [ECW-1:0] ec      [NBLK];

  logic [LAW-1:0] lpa_q;
  logic [DW-1:0]  dat_q, cpy_d;
  logic [LAW-1:0] cpy_own;
  logic [PAW-1:0] cpy_src;
  logic [BAW-1:0] vblk_q, dblk_q;
  logic [OFW-1:0] idx_q;
  logic           mig_q;

  logic [BAW-1:0] vic_blk, cold_blk, dst_blk;
  logic           dst_ok, cold_used;
  logic [ECW-1:0] spread;
  logic [NBLK-1:0] amask;
  logic           alloc_ok;
  logic [PAW-1:0] ap;
  logic [PAW:0]   free_cnt;
  logic [PAW-1:0] src, vbase;
  logic           idx_last, src_live;

  wl_select #(.NBLK(NBLK), .PPB(PPB), .ECW(ECW)) u_sel (
    .pst(pst), .ec(ec), .vic_blk(vic_blk), .cold_blk(cold_blk),
    .dst_blk(dst_blk), .dst_ok(dst_ok), .cold_used(cold_used), .spread(spread)
  );

  always_comb begin
    if (st == S_CPWR)
      amask = mig_q ? (NBLK'(1) << dblk_q) : ~(NBLK'(1) << vblk_q);
    else
      amask = '1;
  end

  wl_alloc #(.NBLK(NBLK), .PPB(PPB)) u_alloc (
    .pst(pst), .blk_mask(amask), .ok(alloc_ok), .ppa(ap), .free_cnt(free_cnt)
  );

  assign vbase    = PAW'(vblk_q) * PAW'(PPB);
  assign src      = vbase + PAW'(idx_q);
  assign idx_last = (idx_q == OFW'(PPB - 1));
  assign src_live = (pst[src] == PG_LIVE);

  assign req_ready = (st == S_IDLE) && !rsp_valid;
  assign fl_rd     = (st == S_RD) || (st == S_CPRD && src_live);
  assign fl_prog   = (st == S_WR) || (st == S_CPWR);
  assign fl_erase  = (st == S_ERASE);
  assign fl_wdata  = (st == S_WR) ? dat_q : cpy_d;

  always_comb begin
    case (st)
      S_RD:    fl_addr = map_ppa[lpa_q];
      S_CPRD:  fl_addr = src;
      S_WR,
      S_CPWR:  fl_addr = ap;
      S_ERASE: fl_addr = vbase;
      default: fl_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      map_ok    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      lpa_q     <= '0;
      dat_q     <= '0;
      cpy_d     <= '0;
      cpy_own   <= '0;
      cpy_src   <= '0;
      vblk_q    <= '0;
      dblk_q    <= '0;
      idx_q     <= '0;
      mig_q     <= 1'b0;
      for (int p = 0; p < NPG; p++) begin
        pst[p] <= PG_ERASED;
        own[p] <= '0;
      end
      for (int l = 0; l < NLP; l++) map_ppa[l] <= '0;
      for (int b = 0; b < NBLK; b++) ec[b] <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid && req_ready) begin
            lpa_q <= req_lpa;
            dat_q <= req_wdata;
            if (req_write) begin
              st <= S_WR;
            end else if (map_ok[req_lpa]) begin
              st <= S_RD;
            end else begin
              rsp_valid <= 1'b1;
              rsp_rdata <= '1;
            end
          end
        end
        S_RD: begin
          rsp_valid <= 1'b1;
          rsp_rdata <= fl_rdata;
          st        <= S_IDLE;
        end
        S_WR: begin
          if (map_ok[lpa_q]) pst[map_ppa[lpa_q]] <= PG_STALE;
          pst[ap]        <= PG_LIVE;
          own[ap]        <= lpa_q;
          map_ppa[lpa_q] <= ap;
          map_ok[lpa_q]  <= 1'b1;
          st <= ((free_cnt - (PAW+1)'(1)) < (PAW+1)'(PPB)) ? S_PICK : S_IDLE;
        end
        S_PICK: begin
          vblk_q <= vic_blk;
          mig_q  <= 1'b0;
          idx_q  <= '0;
          st     <= S_CPRD;
        end
        S_CPRD: begin
          if (src_live) begin
            cpy_d   <= fl_rdata;
            cpy_own <= own[src];
            cpy_src <= src;
            st      <= S_CPWR;
          end else if (idx_last) begin
            st <= S_ERASE;
          end else begin
            idx_q <= idx_q + OFW'(1);
          end
        end
        S_CPWR: begin
          pst[cpy_src]     <= PG_STALE;
          pst[ap]          <= PG_LIVE;
          own[ap]          <= cpy_own;
          map_ppa[cpy_own] <= ap;
          if (idx_last) begin
            st <= S_ERASE;
          end else begin
            idx_q <= idx_q + OFW'(1);
            st    <= S_CPRD;
          end
        end
        S_ERASE: begin
          for (int p = 0; p < NPG; p++)
            if (BAW'(p / PPB) == vblk_q) pst[p] <= PG_ERASED;
          ec[vblk_q] <= ec[vblk_q] + ECW'(1);
          st <= mig_q ? S_IDLE : S_CHKM;
        end
        S_CHKM: begin
          if (spread > lvl_gap_limit && dst_ok && cold_used) begin
            vblk_q <= cold_blk;
            dblk_q <= dst_blk;
            mig_q  <= 1'b1;
            idx_q  <= '0;
            st     <= S_CPRD;
          end else begin
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wl_ftl_chk.sv
module wl_ftl_chk #(
  parameter int DW  = 8,
  parameter int PAW = 4,
  parameter int OFW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic           req_write,
  input logic [DW-1:0]  req_wdata,
  input logic           rsp_valid,
  input logic           rsp_ready,
  input logic [DW-1:0]  rsp_rdata,
  input logic           fl_rd,
  input logic           fl_prog,
  input logic           fl_erase,
  input logic [PAW-1:0] fl_addr,
  input logic [DW-1:0]  fl_wdata,
  input logic           alloc_ok
);
  p_rsp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  p_wr_prog_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write |=> fl_prog && fl_wdata == $past(req_wdata));

  p_prog_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fl_prog |-> alloc_ok);

  p_busy_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_rd || fl_prog || fl_erase) |-> !req_ready);

  p_one_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({fl_rd, fl_prog, fl_erase}) <= 1);

  p_rd_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write |=> fl_rd || rsp_valid);

  p_erase_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fl_erase |-> fl_addr[OFW-1:0] == '0);
endmodule

bind wl_ftl wl_ftl_chk #(.DW(DW), .PAW(PAW), .OFW(OFW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .fl_rd(fl_rd),
  .fl_prog(fl_prog), .fl_erase(fl_erase), .fl_addr(fl_addr),
  .fl_wdata(fl_wdata), .alloc_ok(alloc_ok)
);

// File: tb/wl_ftl_tb_top.sv
module wl_ftl_tb_top;
  localparam int NBLK = 4, PPB = 4, NLP = 8, DW = 8, ECW = 12;
  localparam int NPG = NBLK * PPB, PAW = 4, LAW = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_write, rsp_valid, rsp_ready;
  logic fl_rd, fl_prog, fl_erase;
  logic [LAW-1:0] req_lpa;
  logic [DW-1:0]  req_wdata, rsp_rdata, fl_wdata, fl_rdata;
  logic [PAW-1:0] fl_addr;
  logic [ECW-1:0] thr;
  logic [DW-1:0]  mem [NPG];

  assign fl_rdata = mem[fl_addr];

  wl_ftl #(.NBLK(NBLK), .PPB(PPB), .NLP(NLP), .DW(DW), .ECW(ECW)) dut_i (
    .clk(clk), .rst_n(rst_n), .lvl_gap_limit(thr), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_lpa(req_lpa),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .fl_rd(fl_rd), .fl_prog(fl_prog),
    .fl_erase(fl_erase), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_rdata(fl_rdata)
  );

  int total = 0, bad = 0;
  function automatic void chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endfunction

  // model: 0 erased, 1 live, 2 stale
  int bpst [NPG];
  int bown [NPG];
  int bec  [NBLK];
  int rmap [NLP];
  bit rok  [NLP];
  bit rwr  [NLP];
  logic [DW-1:0] rdat [NLP];
  bit host_pend, wr_open, exp_recl, exp_mig, mig_watch, rd_pend, rd_saw;
  bit prev_hold;
  logic [DW-1:0] prev_data, pend_dat;
  int pend_lpa, rd_lpa, erase_n, last_rd, mig_cnt;

  function automatic int free_pages();
    int n = 0;
    for (int p = 0; p < NPG; p++) if (bpst[p] == 0) n++;
    return n;
  endfunction
  function automatic int stale_in(int b);
    int n = 0;
    for (int o = 0; o < PPB; o++) if (bpst[b*PPB+o] == 2) n++;
    return n;
  endfunction
  function automatic bit blk_used(int b);
    for (int o = 0; o < PPB; o++) if (bpst[b*PPB+o] != 0) return 1'b1;
    return 1'b0;
  endfunction
  function automatic int exp_victim();
    int v = 0;
    for (int b = 1; b < NBLK; b++)
      if (stale_in(b) > stale_in(v) || (stale_in(b) == stale_in(v) && bec[b] < bec[v])) v = b;
    return v;
  endfunction
  function automatic int exp_cold();
    int c = 0;
    for (int b = 1; b < NBLK; b++) if (bec[b] < bec[c]) c = b;
    return c;
  endfunction
  function automatic int gap();
    int mn = bec[0], mx = bec[0];
    for (int b = 1; b < NBLK; b++) begin
      if (bec[b] < mn) mn = bec[b];
      if (bec[b] > mx) mx = bec[b];
    end
    return mx - mn;
  endfunction
  function automatic int exp_dst();
    int d = -1;
    for (int b = 0; b < NBLK; b++)
      if (!blk_used(b) && (d < 0 || bec[b] > bec[d])) d = b;
    return d;
  endfunction
  function automatic void close_op();
    if (wr_open) begin
      chk((erase_n >= 1) == exp_recl, "R4 reclaim iff short of erased pages", erase_n, int'(exp_recl));
      chk((erase_n >= 2) == exp_mig, "R5 migration iff gap over limit", erase_n, int'(exp_mig) + 1);
      wr_open = 1'b0;
    end
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      int a, b, e, v, l;
      a = int'(fl_addr);
      if (prev_hold)
        chk(rsp_valid && rsp_rdata == prev_data, "R7 response held", int'(rsp_rdata), int'(prev_data));
      prev_hold = rsp_valid && !rsp_ready;
      prev_data = rsp_rdata;
      if (fl_rd || fl_prog || fl_erase)
        chk(!req_ready && (int'(fl_rd) + int'(fl_prog) + int'(fl_erase)) == 1,
            "R6 stall and single strobe", int'(req_ready), 0);
      if (fl_rd) begin
        last_rd = a;
        if (rd_pend) rd_saw = 1'b1;
      end
      if (fl_prog) begin
        chk(bpst[a] == 0, "R2 program target erased", bpst[a], 0);
        if (host_pend) begin
          chk(fl_wdata == pend_dat, "R2 program data", int'(fl_wdata), int'(pend_dat));
          if (rok[pend_lpa]) bpst[rmap[pend_lpa]] = 2;
          bpst[a] = 1; bown[a] = pend_lpa; rmap[pend_lpa] = a; rok[pend_lpa] = 1'b1;
          host_pend = 1'b0;
          exp_recl = free_pages() < PPB;
        end else begin
          if (mig_watch) begin
            e = exp_dst();
            chk(a / PPB == e, "R5 migration destination", a / PPB, e);
            mig_watch = 1'b0;
          end
          chk(fl_wdata == mem[last_rd], "R4 copy data", int'(fl_wdata), int'(mem[last_rd]));
          l = bown[last_rd];
          bpst[last_rd] = 2; bpst[a] = 1; bown[a] = l; rmap[l] = a;
        end
        mem[a] = fl_wdata;
      end
      if (fl_erase) begin
        b = a / PPB;
        chk(a % PPB == 0, "R9 erase address aligned", a % PPB, 0);
        v = 0;
        for (int o = 0; o < PPB; o++) if (bpst[b*PPB+o] == 1) v++;
        chk(v == 0, "R4 no live page at erase", v, 0);
        if (erase_n == 0) begin
          e = exp_victim();
          chk(b == e, "R4 victim block", b, e);
        end else begin
          e = exp_cold();
          chk(b == e, "R5 least-worn block moved", b, e);
          chk(gap() > int'(thr), "R5 gap over limit", gap(), int'(thr));
          mig_cnt++;
          mig_watch = 1'b0;
        end
        for (int o = 0; o < PPB; o++) begin
          bpst[b*PPB+o] = 0;
          mem[b*PPB+o] = '1;
        end
        bec[b]++;
        if (erase_n == 0) begin
          e = exp_cold();
          exp_mig = gap() > int'(thr) && exp_dst() >= 0 && blk_used(e);
          mig_watch = exp_mig;
        end
        erase_n++;
      end
      if (rsp_valid && rsp_ready) begin
        if (rwr[rd_lpa]) begin
          chk(rsp_rdata == rdat[rd_lpa], "R1 read data", int'(rsp_rdata), int'(rdat[rd_lpa]));
        end else begin
          chk(rsp_rdata == 8'hFF, "R3 unwritten read value", int'(rsp_rdata), 255);
          chk(!rd_saw, "R3 no array read", int'(rd_saw), 0);
        end
        rd_pend = 1'b0;
      end
      if (req_valid && req_ready) begin
        close_op();
        if (req_write) begin
          host_pend = 1'b1; pend_lpa = int'(req_lpa); pend_dat = req_wdata;
          rdat[req_lpa] = req_wdata; rwr[req_lpa] = 1'b1;
          erase_n = 0; exp_recl = 1'b0; exp_mig = 1'b0; mig_watch = 1'b0; wr_open = 1'b1;
        end else begin
          rd_pend = 1'b1; rd_lpa = int'(req_lpa); rd_saw = 1'b0;
        end
      end
    end
  end

  always @(posedge clk) begin
    #1;
    rsp_ready = ($urandom % 4) != 0;
  end

  task automatic host_op(bit wr, int lpa, int d);
    @(posedge clk); #2;
    req_valid = 1'b1; req_write = wr; req_lpa = LAW'(lpa); req_wdata = DW'(d);
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #2;
    req_valid = 1'b0;
    if (!wr) while (rd_pend) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1_500_000;
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int p = 0; p < NPG; p++) begin mem[p] = '1; bpst[p] = 0; bown[p] = 0; end
    for (int b = 0; b < NBLK; b++) bec[b] = 0;
    for (int l = 0; l < NLP; l++) begin rok[l] = 0; rwr[l] = 0; rmap[l] = 0; rdat[l] = '0; end
    host_pend = 0; wr_open = 0; rd_pend = 0; rd_saw = 0; mig_watch = 0; prev_hold = 0;
    erase_n = 0; mig_cnt = 0; last_rd = 0; exp_recl = 0; exp_mig = 0;
    thr = ECW'(1);
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_lpa = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b0 || rst_n == 1'b0, "R8 in reset", 0, 0);
    @(posedge clk); #2 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 ready after reset", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R8 no response after reset", int'(rsp_valid), 0);
    chk(!fl_rd && !fl_prog && !fl_erase, "R8 no strobes after reset", 1, 0);

    host_op(0, 3, 0);                       // R3 unwritten read
    for (int i = 0; i < 4; i++) host_op(1, i, 8'h10 + i);   // cold set
    for (int i = 0; i < 160; i++) host_op(1, 4 + i % 4, i); // hot set
    chk(mig_cnt > 0, "R5 migration occurred", mig_cnt, 1);
    for (int l = 0; l < NLP; l++) host_op(0, l, 0);         // R1 readback

    for (int i = 0; i < 600; i++) begin
      bit w;
      w = ($urandom % 3) != 0;
      host_op(w, int'($urandom % NLP), int'($urandom % 256));
    end
    for (int l = 0; l < NLP; l++) host_op(0, l, 0);
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule